// File: doc/BRIEF.md
# Shadow Stack Page Permission Checker

This block decides, for one memory access at a time, whether the access may proceed under the shadow-stack page rules. A request carries the resolved leaf permission bits (read, write, execute), the kind of access, the effective privilege level and a flag that says translation is bare. The block returns a registered verdict: permit, access fault or page fault, together with the access class that a trap handler would see (fetch, load or store/AMO).

A leaf entry that is writable but neither readable nor executable is not treated as a reserved encoding. It is treated as a shadow-stack page. Ordinary loads may read such a page. Ordinary stores get a page fault. Fetches and implicit accesses get an access fault. Only the dedicated shadow-stack instructions (push/pop style and atomic swap) may write it. Any fault raised by a shadow-stack instruction is reported with the store/AMO class. Ordinary accesses to any other page go through the usual read/write/execute checks.

The page walk, the TLBs and guest-stage translation sit outside this block. It sees one leaf entry per request, and its verdict appears one clock after the request (parameter `LATENCY`, default 1).

Top module: `sspg_check`

## Requirements
- R1: A leaf entry with read=0, write=1, execute=0 is a shadow-stack page. With translation active and privilege below machine (priv code 0 = user, 1 = supervisor, 3 = machine), an ordinary load (kind 1) to it is permitted with class load (outcome 0 = permit, class 1 = load).
- R2: An ordinary store/AMO (kind 2) to a shadow-stack page, with translation active below machine mode, gives a page fault (outcome 2) with class store (class 2).
- R3: Under the same conditions, a fetch (kind 0) to a shadow-stack page gives an access fault (outcome 1) with class fetch (class 0). An implicit read (kind 5) gives an access fault with class load. An implicit write (kind 6) gives an access fault with class store.
- R4: A shadow-stack instruction (kind 3 = push/pop, kind 4 = swap) with bare translation and privilege below machine gives a store-class access fault, whatever the page bits are.
- R5: At machine privilege a swap (kind 4) always gives a store-class access fault. A push/pop (kind 3) at machine privilege is permitted with class store.
- R6: A shadow-stack instruction below machine mode with translation active, aimed at a page that is not a shadow-stack page, gives a store-class page fault.
- R7: Every verdict for a shadow-stack instruction carries class store. A swap or push/pop to a shadow-stack page with translation active below machine mode is permitted.
- R8: On a page that is not a shadow-stack page, with translation active below machine mode, ordinary accesses need these bits: fetch needs execute, load and implicit read need read, store and implicit write need read and write. A missing bit gives a page fault of the access's own class. The encoding read=0, write=1, execute=1 always gives a page fault. Kind 7 is handled as an implicit write.
- R9: Ordinary accesses (kinds 0, 1, 2, 5, 6, 7) are permitted with their own class when translation is bare or privilege is machine, even on a shadow-stack page.
- R10: The verdict appears on the response outputs exactly LATENCY clocks after the request, with rsp_valid set. When no request was presented, rsp_valid, rsp_outcome and rsp_class all read zero. Reset clears all three.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented this cycle |
| pte_r | input | 1 | Leaf entry read permission |
| pte_w | input | 1 | Leaf entry write permission |
| pte_x | input | 1 | Leaf entry execute permission |
| acc_kind | input | 3 | Access kind code (0 fetch, 1 load, 2 store/AMO, 3 shadow-stack push/pop, 4 shadow-stack swap, 5 implicit read, 6 implicit write, 7 handled as implicit write) |
| priv | input | 2 | Effective privilege (0 user, 1 supervisor, 3 machine) |
| xlat_bare | input | 1 | Translation is bare for this access |
| rsp_valid | output | 1 | Verdict valid |
| rsp_outcome | output | 2 | 0 permit, 1 access fault, 2 page fault |
| rsp_class | output | 2 | 0 fetch, 1 load, 2 store/AMO |

## Verification
Each access kind is driven against a shadow-stack page, against pages with one permission bit missing, against a fully permissive page and against the reserved write-plus-execute encoding. These runs show that the shadow-stack path is kept apart from the ordinary permission checks. Each kind is also repeated with bare translation and at machine privilege. Those runs show which rules are skipped and which still fire: swap at machine level, and shadow-stack instructions under bare translation. Push/pop and swap are compared at machine level to show that the two differ, and idle cycles between requests show that no verdict leaks out when no request was made.

// File: rtl/sspg_pkg.sv
package sspg_pkg;
  localparam int KIND_W = 3;
  localparam int PRIV_W = 2;
  localparam int OUT_W  = 2;
  localparam int CLS_W  = 2;

  typedef enum logic [KIND_W-1:0] {
    K_FETCH   = 3'd0,
    K_LOAD    = 3'd1,
    K_STORE   = 3'd2,
    K_SS_PP   = 3'd3,
    K_SS_SWAP = 3'd4,
    K_IMPL_RD = 3'd5,
    K_IMPL_WR = 3'd6,
    K_SPARE   = 3'd7
  } kind_t;

  typedef enum logic [OUT_W-1:0] {
    OUT_PERMIT = 2'd0,
    OUT_ACCESS = 2'd1,
    OUT_PAGE   = 2'd2
  } outcome_t;

  typedef enum logic [CLS_W-1:0] {
    CLS_FETCH = 2'd0,
    CLS_LOAD  = 2'd1,
    CLS_STORE = 2'd2
  } class_t;

  localparam logic [PRIV_W-1:0] PRIV_MACHINE = 2'd3;

  typedef struct packed {
    logic     v;
    outcome_t o;
    class_t   c;
  } verdict_t;

  // Write-only leaf encoding is the shadow-stack page type.
  function automatic logic perm_is_ss(input logic r, input logic w, input logic x);
    return !r && w && !x;
  endfunction

  // Writable-executable without read stays reserved.
  function automatic logic perm_is_rsvd(input logic r, input logic w, input logic x);
    return !r && w && x;
  endfunction

  function automatic logic kind_is_ss(input kind_t k);
    return (k == K_SS_PP) || (k == K_SS_SWAP);
  endfunction

  // Class a fault would be reported with for an ordinary access kind.
  function automatic class_t natural_class(input kind_t k);
    case (k)
      K_FETCH:   return CLS_FETCH;
      K_LOAD,
      K_IMPL_RD: return CLS_LOAD;
      default:   return CLS_STORE;
    endcase
  endfunction

  // Standard permission test for ordinary access kinds.
  function automatic logic plain_grant(input kind_t k, input logic r, input logic w,
                                       input logic x);
    case (k)
      K_FETCH:   return x;
      K_LOAD,
      K_IMPL_RD: return r;
      default:   return r && w;
    endcase
  endfunction

  // Ordinary access that is a true implicit (non-instruction) reference.
  function automatic logic kind_is_implicit(input kind_t k);
    return (k == K_IMPL_RD) || (k == K_IMPL_WR) || (k == K_SPARE);
  endfunction
endpackage

// File: rtl/sspg_decode.sv
module sspg_decode
  import sspg_pkg::*;
(
  input  logic              pte_r,
  input  logic              pte_w,
  input  logic              pte_x,
  input  logic [KIND_W-1:0] acc_kind,
  input  logic [PRIV_W-1:0] priv,
  input  logic              xlat_bare,
  output kind_t             kind,
  output logic              page_ss,
  output logic              page_rsvd,
  output logic              is_ss_ins,
  output logic              is_swap,
  output logic              at_machine,
  output logic              checks_off,
  output class_t            own_class
);
  always_comb begin
    kind       = kind_t'(acc_kind);
    page_ss    = perm_is_ss(pte_r, pte_w, pte_x);
    page_rsvd  = perm_is_rsvd(pte_r, pte_w, pte_x);
    is_ss_ins  = kind_is_ss(kind);
    is_swap    = (kind == K_SS_SWAP);
    at_machine = (priv == PRIV_MACHINE);
    checks_off = xlat_bare || at_machine;
    own_class  = natural_class(kind);
  end
endmodule

// File: rtl/sspg_ss_rules.sv
module sspg_ss_rules
  import sspg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     active,
  input  logic     is_swap,
  input  logic     at_machine,
  input  logic     xlat_bare,
  input  logic     page_ss,
  output outcome_t ss_outcome,
  output class_t   ss_class
);
  logic swap_in_machine;
  logic bare_below_machine;
  logic wrong_page;

  always_comb begin
    swap_in_machine    = at_machine && is_swap;
    bare_below_machine = !at_machine && xlat_bare;
    wrong_page         = !at_machine && !xlat_bare && !page_ss;
    ss_class           = CLS_STORE;
    if (swap_in_machine || bare_below_machine) ss_outcome = OUT_ACCESS;
    else if (wrong_page)                        ss_outcome = OUT_PAGE;
    else                                        ss_outcome = OUT_PERMIT;
  end

  a_r5_swap_machine_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (active && swap_in_machine) |-> (ss_outcome == OUT_ACCESS));
  a_r4_bare_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (active && bare_below_machine) |-> (ss_outcome == OUT_ACCESS));
  a_r6_wrong_page: assert property (@(posedge clk) disable iff (!rst_n)
    (active && wrong_page) |-> (ss_outcome == OUT_PAGE));
endmodule

// File: rtl/sspg_plain_rules.sv
module sspg_plain_rules
  import sspg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     active,
  input  kind_t    kind,
  input  logic     pte_r,
  input  logic     pte_w,
  input  logic     pte_x,
  input  logic     page_ss,
  input  logic     page_rsvd,
  input  logic     checks_off,
  input  class_t   own_class,
  output outcome_t pl_outcome,
  output class_t   pl_class
);
  logic ss_fetch_or_implicit;
  logic ss_store;
  logic perm_miss;

  always_comb begin
    ss_fetch_or_implicit = page_ss && ((kind == K_FETCH) || kind_is_implicit(kind));
    ss_store             = page_ss && (kind == K_STORE);
    perm_miss            = page_rsvd || !plain_grant(kind, pte_r, pte_w, pte_x);
    pl_class             = own_class;
    if (checks_off)                pl_outcome = OUT_PERMIT;
    else if (ss_fetch_or_implicit) pl_outcome = OUT_ACCESS;
    else if (ss_store)             pl_outcome = OUT_PAGE;
    else if (page_ss)              pl_outcome = OUT_PERMIT;
    else if (perm_miss)            pl_outcome = OUT_PAGE;
    else                           pl_outcome = OUT_PERMIT;
  end

  a_r1_ss_load_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !checks_off && page_ss && kind == K_LOAD) |-> (pl_outcome == OUT_PERMIT));
  a_r3_ss_fetch_access: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !checks_off && page_ss && kind == K_FETCH) |->
      (pl_outcome == OUT_ACCESS && pl_class == CLS_FETCH));
  a_r9_checks_off_permit: assert property (@(posedge clk) disable iff (!rst_n)
    (active && checks_off) |-> (pl_outcome == OUT_PERMIT));
endmodule

// File: rtl/sspg_check.sv
module sspg_check
  import sspg_pkg::*;
#(
  parameter int LATENCY = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              pte_r,
  input  logic              pte_w,
  input  logic              pte_x,
  input  logic [KIND_W-1:0] acc_kind,
  input  logic [PRIV_W-1:0] priv,
  input  logic              xlat_bare,
  output logic              rsp_valid,
  output logic [OUT_W-1:0]  rsp_outcome,
  output logic [CLS_W-1:0]  rsp_class
);
  kind_t    kind;
  logic     page_ss, page_rsvd, is_ss_ins, is_swap, at_machine, checks_off;
  class_t   own_class;
  outcome_t ss_outcome, pl_outcome;
  class_t   ss_class, pl_class;
  logic     ss_active, pl_active;
  verdict_t verdict_d;

  sspg_decode u_dec (
    .pte_r(pte_r), .pte_w(pte_w), .pte_x(pte_x), .acc_kind(acc_kind), .priv(priv),
    .xlat_bare(xlat_bare), .kind(kind), .page_ss(page_ss), .page_rsvd(page_rsvd),
    .is_ss_ins(is_ss_ins), .is_swap(is_swap), .at_machine(at_machine),
    .checks_off(checks_off), .own_class(own_class)
  );

  assign ss_active = req_valid && is_ss_ins;
  assign pl_active = req_valid && !is_ss_ins;

  sspg_ss_rules u_ss (
    .clk(clk), .rst_n(rst_n), .active(ss_active), .is_swap(is_swap),
    .at_machine(at_machine), .xlat_bare(xlat_bare), .page_ss(page_ss),
    .ss_outcome(ss_outcome), .ss_class(ss_class)
  );

  sspg_plain_rules u_pl (
    .clk(clk), .rst_n(rst_n), .active(pl_active), .kind(kind), .pte_r(pte_r),
    .pte_w(pte_w), .pte_x(pte_x), .page_ss(page_ss), .page_rsvd(page_rsvd),
    .checks_off(checks_off), .own_class(own_class), .pl_outcome(pl_outcome),
    .pl_class(pl_class)
  );

  always_comb begin
    verdict_d = '0;
    if (req_valid) begin
      verdict_d.v = 1'b1;
      verdict_d.o = is_ss_ins ? ss_outcome : pl_outcome;
      verdict_d.c = is_ss_ins ? ss_class : pl_class;
    end
  end

  verdict_t stage_q [LATENCY];

  for (genvar i = 0; i < LATENCY; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= verdict_d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q[i] <= '0;
        else        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign rsp_valid   = stage_q[LATENCY-1].v;
  assign rsp_outcome = stage_q[LATENCY-1].o;
  assign rsp_class   = stage_q[LATENCY-1].c;

  a_r7_ss_store_class: assert property (@(posedge clk) disable iff (!rst_n)
    ss_active |-> (verdict_d.c == CLS_STORE));
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_outcome == 2'd0 && rsp_class == 2'd0));
  a_r10_legal_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_outcome != 2'd3 && rsp_class != 2'd3));

  if (LATENCY == 1) begin : g_lat1_chk
    a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
    a_r10_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
  end
endmodule

// File: tb/sspg_check_test.sv
module sspg_check_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       pte_r = 1'b0, pte_w = 1'b0, pte_x = 1'b0;
  logic [2:0] acc_kind = 3'd0;
  logic [1:0] priv = 2'd0;
  logic       xlat_bare = 1'b0;
  logic       rsp_valid;
  logic [1:0] rsp_outcome, rsp_class;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  sspg_check uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .pte_r(pte_r), .pte_w(pte_w),
    .pte_x(pte_x), .acc_kind(acc_kind), .priv(priv), .xlat_bare(xlat_bare),
    .rsp_valid(rsp_valid), .rsp_outcome(rsp_outcome), .rsp_class(rsp_class)
  );

  // Vector: req[16:13] rwx[12:10] kind[9:7] priv[6:5] bare[4] outcome[3:2] class[1:0]
  localparam int NV = 22;
  localparam logic [16:0] VEC [NV] = '{
    {4'd1,  3'b010, 3'd1, 2'd0, 1'b0, 2'd0, 2'd1}, // R1 load on shadow page
    {4'd2,  3'b010, 3'd2, 2'd1, 1'b0, 2'd2, 2'd2}, // R2 store on shadow page
    {4'd3,  3'b010, 3'd0, 2'd0, 1'b0, 2'd1, 2'd0}, // R3 fetch
    {4'd3,  3'b010, 3'd5, 2'd1, 1'b0, 2'd1, 2'd1}, // R3 implicit read
    {4'd3,  3'b010, 3'd6, 2'd1, 1'b0, 2'd1, 2'd2}, // R3 implicit write
    {4'd4,  3'b010, 3'd3, 2'd1, 1'b1, 2'd1, 2'd2}, // R4 push/pop bare
    {4'd4,  3'b110, 3'd4, 2'd0, 1'b1, 2'd1, 2'd2}, // R4 swap bare
    {4'd5,  3'b010, 3'd4, 2'd3, 1'b0, 2'd1, 2'd2}, // R5 swap machine
    {4'd5,  3'b000, 3'd3, 2'd3, 1'b1, 2'd0, 2'd2}, // R5 push/pop machine
    {4'd6,  3'b110, 3'd3, 2'd1, 1'b0, 2'd2, 2'd2}, // R6 push/pop on RW page
    {4'd6,  3'b100, 3'd4, 2'd0, 1'b0, 2'd2, 2'd2}, // R6 swap on R page
    {4'd7,  3'b010, 3'd4, 2'd1, 1'b0, 2'd0, 2'd2}, // R7 swap on shadow page
    {4'd8,  3'b101, 3'd0, 2'd0, 1'b0, 2'd0, 2'd0}, // R8 fetch with X
    {4'd8,  3'b110, 3'd0, 2'd0, 1'b0, 2'd2, 2'd0}, // R8 fetch without X
    {4'd8,  3'b001, 3'd1, 2'd1, 1'b0, 2'd2, 2'd1}, // R8 load without R
    {4'd8,  3'b100, 3'd2, 2'd0, 1'b0, 2'd2, 2'd2}, // R8 store without W
    {4'd8,  3'b110, 3'd2, 2'd0, 1'b0, 2'd0, 2'd2}, // R8 store with RW
    {4'd8,  3'b011, 3'd1, 2'd0, 1'b0, 2'd2, 2'd1}, // R8 reserved W+X
    {4'd8,  3'b111, 3'd6, 2'd1, 1'b0, 2'd0, 2'd2}, // R8 implicit write RWX
    {4'd9,  3'b010, 3'd2, 2'd3, 1'b0, 2'd0, 2'd2}, // R9 store machine
    {4'd9,  3'b010, 3'd0, 2'd1, 1'b1, 2'd0, 2'd0}, // R9 fetch bare
    {4'd8,  3'b100, 3'd7, 2'd1, 1'b0, 2'd2, 2'd2}  // R8 kind 7 as implicit write
  };

  task automatic check(input string tag, input logic [4:0] got, input logic [4:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got v=%0b o=%0d c=%0d expected v=%0b o=%0d c=%0d",
               tag, got[4], got[3:2], got[1:0], exp[4], exp[3:2], exp[1:0]);
    end
  endtask

  task automatic apply(input logic [16:0] v);
    req_valid = 1'b1;
    {pte_r, pte_w, pte_x} = v[12:10];
    acc_kind  = v[9:7];
    priv      = v[6:5];
    xlat_bare = v[4];
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 reset", {rsp_valid, rsp_outcome, rsp_class}, 5'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after reset idle", {rsp_valid, rsp_outcome, rsp_class}, 5'b0);

    // Table walk, one request per cycle, back to back
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VEC[i][16:13], i),
            {rsp_valid, rsp_outcome, rsp_class}, {1'b1, VEC[i][3:0]});
    end

    // R10: no request with fault-provoking inputs gives zero outputs
    req_valid = 1'b0;
    {pte_r, pte_w, pte_x} = 3'b010;
    acc_kind = 3'd2; priv = 2'd1; xlat_bare = 1'b0;
    @(negedge clk);
    check("R10 idle no verdict", {rsp_valid, rsp_outcome, rsp_class}, 5'b0);

    // R10: single request then idle, verdict lasts exactly one cycle
    apply(VEC[1]);
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 single request", {rsp_valid, rsp_outcome, rsp_class}, {1'b1, 4'b1010});
    @(negedge clk);
    check("R10 verdict drops", {rsp_valid, rsp_outcome, rsp_class}, 5'b0);

    // R5/R7: push/pop vs swap on shadow page at machine, translation active
    apply({4'd5, 3'b010, 3'd3, 2'd3, 1'b0, 4'b0010});
    @(negedge clk);
    check("R5 push/pop machine shadow page", {rsp_valid, rsp_outcome, rsp_class}, 5'b10010);
    apply({4'd5, 3'b010, 3'd4, 2'd3, 1'b1, 4'b0110});
    @(negedge clk);
    check("R5 swap machine bare", {rsp_valid, rsp_outcome, rsp_class}, 5'b10110);

    // R10: reset in mid-stream clears the response
    apply(VEC[2]);
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 reset clears", {rsp_valid, rsp_outcome, rsp_class}, 5'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R3 after reset", {rsp_valid, rsp_outcome, rsp_class}, 5'b10100);
    req_valid = 1'b0;
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule